// File: doc/BRIEF.md
# Double-Edge Tree 8:1 Serializer

This block turns an 8-bit parallel word into a serial bit stream, one bit per cycle of the bit clock. The multiplexing is done by a three-level binary tree of two-register cells. There are four cells at the leaves, two in the middle and one at the output. Each cell keeps two stored bits. One is refreshed when its stage phase rises and the other when it falls. The phase level picks which of the two drives the cell's output. The stage phases run at one half (output cell), one quarter (middle) and one eighth (leaves) of the bit rate. All three are derived from a single bit-rate clock by a small divider.

The leaves take their bit pairs in bit-reversed placement: leaf 0 gets bits 0 and 4, leaf 1 gets bits 2 and 6, leaf 2 gets bits 1 and 5, and leaf 3 gets bits 3 and 7. With this placement the tree emits the word in natural bit order. A straight placement would swap the middle bits of each half. The user presents a word on `parWord` and watches `wordTake`. The word is taken at the rising edge that ends a cycle in which `wordTake` is high. Its bits then leave `serOut` starting three edges later.

Top module: `dtree_serializer`

## Requirements
- R1: `serOut` sends `parWord[0]` through `parWord[7]` of each captured word in ascending index order, one bit per `clkBit` cycle. The next word's bit 0 follows bit 7 directly, with no idle cycle.
- R2: `wordTake` is high in exactly one cycle out of every eight and is never high in two consecutive cycles.
- R3: `wordTake` is high during reset and in the first cycle after `rstN` rises. The value on `parWord` at the first rising edge after release is the first word sent.
- R4: `serOut` is 0 during reset and until the fourth rising edge after release. Bit 0 of the first word is on `serOut` right after that fourth edge.
- R5: `parWord` is sampled only at the rising edge that ends a `wordTake` cycle. Values it holds at any other edge have no effect on `serOut`.
- R6: A word with a single bit set at index k gives exactly one high bit in its frame, in cycle k (cycle 0 carries bit 0). The word 8'h6B (bit 0 first: 1,1,0,1,0,1,1,0) is sent as that same sequence.
- R7: Pulling the active-low asynchronous `rstN` low at any time forces `serOut` to 0 immediately. Framing then restarts exactly as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkBit | input | 1 | Bit-rate clock; one serial bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| parWord | input | 8 | Parallel word, bit 0 sent first |
| wordTake | output | 1 | High in the cycle whose closing rising edge samples `parWord` |
| serOut | output | 1 | Serial data output |

## Verification
The bench feeds single-bit words, including one for each bit position, along with the alternating and all-zero/all-one patterns. A tree with the leaf pairs placed in straight order would make those lone ones come out in the wrong cycle. Between capture edges, `parWord` is filled with random garbage. A design that samples the word at the wrong edge, or lets leaves reload from the live input, would corrupt the stream. Each session checks the exact cycle in which the first bit emerges after reset, so an off-by-one in the divider start value or in a level's phase offset shows up as a shifted frame. A reset in the middle of a frame followed by a fresh session catches a divider or tree register that fails to clear.

// File: rtl/dtree_pkg.sv
package dtree_pkg;

  // Tree depth; the word width and slot counter follow from it.
  localparam int unsigned TREE_LEVELS = 3;
  localparam int unsigned WORD_BITS   = 1 << TREE_LEVELS;
  localparam int unsigned SLOT_BITS   = TREE_LEVELS;

  // Strobes from control to datapath, one field bit per tree depth
  // (depth 0 is the output cell, depth TREE_LEVELS-1 the leaves).
  typedef struct packed {
    logic                   wordCap;
    logic [TREE_LEVELS-1:0] phase;
    logic [TREE_LEVELS-1:0] loadHi;
    logic [TREE_LEVELS-1:0] loadLo;
  } strobe_t;

  // Reverse the lowest w bits of v.
  function automatic int unsigned bitRev(input int unsigned v, input int unsigned w);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < w; i++) begin
      r = (r << 1) | ((v >> i) & 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/dtree_ctrl.sv
module dtree_ctrl
  import dtree_pkg::*;
(
  input  logic    clkBit,
  input  logic    rstN,
  output strobe_t stb
);

  // Slot in which the word register is loaded at the closing edge.
  localparam logic [SLOT_BITS-1:0] CAP_SLOT = SLOT_BITS'(WORD_BITS - TREE_LEVELS - 1);

  logic [SLOT_BITS-1:0]   slot;
  logic [SLOT_BITS-1:0]   slotNext;
  logic [TREE_LEVELS-1:0] phNow;
  logic [TREE_LEVELS-1:0] phNext;

  // Stage phase at depth d: period 2^(d+1) slots, advanced by d slots so
  // each level has its value ready one slot before the level above samples.
  function automatic logic phaseOf(input logic [SLOT_BITS-1:0] s, input int unsigned d);
    logic [SLOT_BITS:0] sh;
    sh = ({1'b0, s} + (SLOT_BITS+1)'(d)) >> d;
    return ~sh[0];
  endfunction

  assign slotNext = slot + 1'b1;

  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN) slot <= CAP_SLOT;
    else       slot <= slotNext;
  end

  always_comb begin
    for (int unsigned d = 0; d < TREE_LEVELS; d++) begin
      phNow[d]  = phaseOf(slot, d);
      phNext[d] = phaseOf(slotNext, d);
    end
  end

  always_comb begin
    stb.wordCap = (slot == CAP_SLOT);
    stb.phase   = phNow;
    stb.loadHi  = phNext & ~phNow;
    stb.loadLo  = ~phNext & phNow;
  end

endmodule

// File: rtl/dtree_cell.sv
module dtree_cell (
  input  logic clkBit,
  input  logic rstN,
  input  logic loadHi,
  input  logic loadLo,
  input  logic phase,
  input  logic dHi,
  input  logic dLo,
  output logic q
);

  logic hiQ;
  logic loQ;

  // One register refreshed as the phase rises, the other as it falls.
  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN) begin
      hiQ <= 1'b0;
      loQ <= 1'b0;
    end else begin
      if (loadHi) hiQ <= dHi;
      if (loadLo) loQ <= dLo;
    end
  end

  assign q = phase ? hiQ : loQ;

endmodule

// File: rtl/dtree_path.sv
module dtree_path
  import dtree_pkg::*;
(
  input  logic                 clkBit,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] parWord,
  input  strobe_t              stb,
  output logic                 serOut
);

  localparam int unsigned LEAVES = WORD_BITS / 2;
  localparam int unsigned NODES  = WORD_BITS - 1;

  logic [WORD_BITS-1:0] wordQ;
  logic [NODES:1]       nodeQ;   // heap order: node k feeds from 2k and 2k+1

  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN)            wordQ <= '0;
    else if (stb.wordCap) wordQ <= parWord;
  end

  for (genvar d = 0; d < TREE_LEVELS; d++) begin : g_lvl
    for (genvar i = 0; i < (1 << d); i++) begin : g_cell
      localparam int unsigned K = (1 << d) + i;
      logic hiIn;
      logic loIn;
      if (d == TREE_LEVELS - 1) begin : g_leaf
        // Bit-reversed placement gives natural output order.
        localparam int unsigned BI = bitRev(i, TREE_LEVELS - 1);
        assign hiIn = wordQ[BI];
        assign loIn = wordQ[BI + LEAVES];
      end else begin : g_node
        assign hiIn = nodeQ[2*K];
        assign loIn = nodeQ[2*K + 1];
      end
      dtree_cell u_cell (
        .clkBit (clkBit),
        .rstN   (rstN),
        .loadHi (stb.loadHi[d]),
        .loadLo (stb.loadLo[d]),
        .phase  (stb.phase[d]),
        .dHi    (hiIn),
        .dLo    (loIn),
        .q      (nodeQ[K])
      );
    end
  end

  assign serOut = nodeQ[1];

endmodule

// File: rtl/dtree_serializer.sv
module dtree_serializer
  import dtree_pkg::*;
(
  input  logic                 clkBit,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] parWord,
  output logic                 wordTake,
  output logic                 serOut
);

  strobe_t stb;

  dtree_ctrl u_ctrl (
    .clkBit (clkBit),
    .rstN   (rstN),
    .stb    (stb)
  );

  dtree_path u_path (
    .clkBit  (clkBit),
    .rstN    (rstN),
    .parWord (parWord),
    .stb     (stb),
    .serOut  (serOut)
  );

  assign wordTake = stb.wordCap;

endmodule

// File: rtl/dtree_serializer_chk.sv
module dtree_serializer_chk
  import dtree_pkg::*;
(
  input logic                 clkBit,
  input logic                 rstN,
  input logic [WORD_BITS-1:0] parWord,
  input logic                 wordTake,
  input logic                 serOut
);

  localparam int unsigned LAT = TREE_LEVELS;  // capture edge to bit 0
  localparam logic [SLOT_BITS-1:0] FIRST_SLOT = SLOT_BITS'(WORD_BITS - TREE_LEVELS);

  logic [SLOT_BITS-1:0] pos;
  logic [SLOT_BITS-1:0] gap;
  logic [SLOT_BITS-1:0] slotNow;
  logic [1:0]           takes;
  logic [3:0]           sinceRst;
  logic [WORD_BITS-1:0] curW;
  logic [WORD_BITS-1:0] prevW;
  logic                 expValid;
  logic                 expBit;

  always_ff @(posedge clkBit or negedge rstN) begin
    if (!rstN) begin
      pos      <= '0;
      gap      <= '0;
      takes    <= '0;
      sinceRst <= '0;
      curW     <= '0;
      prevW    <= '0;
    end else begin
      if (wordTake) begin
        prevW <= curW;
        curW  <= parWord;
        pos   <= '0;
        gap   <= '0;
        if (takes != 2'd2) takes <= takes + 1'b1;
      end else begin
        pos <= pos + 1'b1;
        gap <= gap + 1'b1;
      end
      if (sinceRst != 4'hF) sinceRst <= sinceRst + 1'b1;
    end
  end

  assign slotNow = pos + FIRST_SLOT;

  always_comb begin
    if (pos >= SLOT_BITS'(LAT)) begin
      expValid = (takes != 2'd0);
      expBit   = curW[slotNow];
    end else begin
      expValid = (takes == 2'd2);
      expBit   = prevW[slotNow];
    end
  end

  // R1 and R5: stream equals captured words in bit order.
  p_stream_order_r1: assert property (@(posedge clkBit) disable iff (!rstN)
    expValid |-> (serOut == expBit));

  p_take_gap_r2: assert property (@(posedge clkBit) disable iff (!rstN)
    (wordTake && takes != 2'd0) |-> (gap == SLOT_BITS'(WORD_BITS - 1)));

  p_take_single_r2: assert property (@(posedge clkBit) disable iff (!rstN)
    wordTake |=> !wordTake);

  p_first_take_r3: assert property (@(posedge clkBit) disable iff (!rstN)
    (sinceRst == 4'd0) |-> wordTake);

  p_quiet_start_r4: assert property (@(posedge clkBit) disable iff (!rstN)
    (sinceRst < 4'(LAT + 1)) |-> !serOut);

endmodule

bind dtree_serializer dtree_serializer_chk u_chk (
  .clkBit   (clkBit),
  .rstN     (rstN),
  .parWord  (parWord),
  .wordTake (wordTake),
  .serOut   (serOut)
);

// File: tb/dtree_serializer_tb_top.sv
module dtree_serializer_tb_top;

  localparam int W = 8;

  logic         clkBit = 1'b0;
  logic         rstN;
  logic [W-1:0] parWord = '0;
  logic         wordTake;
  logic         serOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic expQ [0:4095];
  int   wrIdx = 0;

  always #2 clkBit = ~clkBit;   // 250 MHz

  dtree_serializer dut_i (
    .clkBit   (clkBit),
    .rstN     (rstN),
    .parWord  (parWord),
    .wordTake (wordTake),
    .serOut   (serOut)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] dirWord(input int idx);
    case (idx)
      0:       return 8'h6B;   // 1,1,0,1,0,1,1,0 bit 0 first
      1:       return 8'h00;
      2:       return 8'hFF;
      3:       return 8'h55;
      4:       return 8'hAA;
      13:      return 8'hFE;
      default: return W'(1) << (idx - 5);
    endcase
  endfunction

  task automatic doReset(input string tag);
    @(negedge clkBit);
    rstN    = 1'b0;
    parWord = W'($urandom);
    repeat (3) begin
      @(negedge clkBit);
      chk(serOut, 1'b0, tag, "serOut in reset");
      chk(wordTake, 1'b1, tag, "wordTake in reset");
    end
  endtask

  // Released at the current negedge; e counts rising edges since release.
  task automatic runSession(input int nFrames, input int nEdges, input string tag, input bit directed);
    int pushed;
    logic [W-1:0] w;
    pushed = 0;
    wrIdx  = 0;
    rstN   = 1'b1;
    for (int e = 0; e < nEdges; e++) begin
      if (e > 0) @(negedge clkBit);
      if (e < 4)               chk(serOut, 1'b0, "R4", "serOut before first bit");
      else if (e - 4 < wrIdx)  chk(serOut, expQ[e-4], tag, "serial bit");
      chk(wordTake, (e % 8 == 0), (e == 0) ? "R3" : "R2", "wordTake");
      if ((e % 8 == 0) && (pushed < nFrames)) begin
        w = directed ? dirWord(pushed) : W'($urandom);
        for (int b = 0; b < W; b++) begin
          expQ[wrIdx] = w[b];
          wrIdx++;
        end
        pushed++;
        parWord = w;
      end else begin
        parWord = W'($urandom);   // R5: garbage between capture edges
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    rstN = 1'b1;
    #1 rstN = 1'b0;
    doReset("R3");
    runSession(14, 8*14 + 4, "R6", 1'b1);
    doReset("R7");
    runSession(40, 8*40 + 4, "R1+R5", 1'b0);
    doReset("R7");
    runSession(5, 13, "R7", 1'b0);       // cut short mid-frame
    doReset("R7");
    runSession(10, 8*10 + 4, "R7", 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule